// File: doc/BRIEF.md
# Byte-to-Word Packing FIFO

This block is a single-clock synchronous FIFO. Its write port takes one byte per accepted write and its read port delivers one 32-bit word. Every four accepted bytes are merged into one wide entry. A design-time parameter picks the lane order. In FIRST_HIGH order the earliest byte of a group sits in the top lane. In FIRST_LOW order the earliest byte sits in the bottom lane. The block lets a byte-oriented producer feed a word-oriented consumer without an extra conversion stage.

The read side is first-word-fall-through. Whenever `empty` is low, `dout` already holds the oldest complete word, and asserting `rd_en` removes that word. Fill level is counted in byte entries, and this count includes any bytes waiting in an incomplete group. The block derives `full` and a programmable-full flag from that count. A write that arrives while the FIFO is full is rejected, and so is a read that arrives while it is empty. In both cases the stored data is left untouched, and a one-cycle error flag is raised on the next cycle.

Top module: `byte_pack_fifo`

## Requirements
- R1: Four accepted bytes form one word. With fewer than four bytes of a new group written, no word appears on the read side and `empty` stays high.
- R2: With ORDER = FIRST_HIGH, the first byte of a group appears on `dout[31:24]`, the second on `dout[23:16]`, the third on `dout[15:8]` and the fourth on `dout[7:0]`.
- R3: With ORDER = FIRST_LOW, the first byte of a group appears on `dout[7:0]`, the second on `dout[15:8]`, the third on `dout[23:16]` and the fourth on `dout[31:24]`.
- R4: Read is first-word-fall-through. After the clock edge that accepts the fourth byte of a group into an empty FIFO, `empty` is low and `dout` shows that word. A cycle with `rd_en` high and `empty` low removes the head word, and the next word, if any, is shown after that edge. While `empty` is low and `rd_en` is low, `dout` holds its value.
- R5: `full` is high exactly when 1024 byte entries are stored. A write while `full` is high stores nothing, does not advance the byte position within a group, and leaves every stored word intact.
- R6: `overflow` is high for the one cycle that follows an edge at which `wr_en` was high while `full` was high. It is low at all other times.
- R7: `underflow` is high for the one cycle that follows an edge at which `rd_en` was high while `empty` was high. It is low at all other times.
- R8: `prog_full` is high when the stored byte count, counting bytes of an incomplete group, is at or above PFULL_THRESH (default 500). It is low when the count is below PFULL_THRESH.
- R9: A synchronous high `rst` empties the FIFO, discards any incomplete group, clears `full`, `prog_full`, `overflow` and `underflow`, sets `empty`, and drives `dout` to zero.
- R10: When the fourth byte of a group is accepted in the same cycle that the only stored word is read, the new word is shown on `dout` with `empty` low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for the byte on `din` |
| din | input | 8 | Write byte |
| rd_en | input | 1 | Pop request for the head word |
| dout | output | 32 | Head word, valid while `empty` is low |
| full | output | 1 | 1024 byte entries stored |
| empty | output | 1 | No complete word stored |
| prog_full | output | 1 | Byte count at or above PFULL_THRESH |
| overflow | output | 1 | Previous-cycle write was rejected |
| underflow | output | 1 | Previous-cycle read was rejected |

## Verification
Two events can fall in the same cycle and are hard to get right together. The write side can complete a word in the very cycle the read side pops the last stored word. The new word's memory slot is then the one that becomes the read address. The bench provokes this by holding one word and three bytes of a new group, then raising `wr_en` with the fourth byte and `rd_en` together. It judges the result by `empty` staying low after that edge and `dout` showing the new word in the configured lane order. Two instances run side by side with opposite lane orders and different thresholds. The threshold is also tested at a byte count that is not a multiple of four, so a word-only count would give a wrong `prog_full`.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  // Which lane of the wide word receives the earliest byte of a group
  typedef enum logic {
    FIRST_HIGH = 1'b0,
    FIRST_LOW  = 1'b1
  } lane_order_e;
endpackage

// File: rtl/bpf_packer.sv
module bpf_packer
  import bpf_pkg::*;
#(
  parameter int          IN_W  = 8,
  parameter int          RATIO = 4,
  parameter lane_order_e ORDER = FIRST_HIGH,
  localparam int         OUT_W = IN_W * RATIO,
  localparam int         LW    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [IN_W-1:0]  byte_in,
  output logic [LW-1:0]    lane,
  output logic             word_done,
  output logic [OUT_W-1:0] word
);
  logic [OUT_W-1:0] acc;
  logic [OUT_W-1:0] merged;

  generate
    if (ORDER == FIRST_HIGH) begin : g_high
      // older bytes shift toward the top lane
      assign merged = {acc[OUT_W-IN_W-1:0], byte_in};
    end else begin : g_low
      // older bytes shift toward the bottom lane
      assign merged = {byte_in, acc[OUT_W-1:IN_W]};
    end
  endgenerate

  assign word_done = take && (lane == LW'(RATIO - 1));
  assign word      = merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      lane <= '0;
    end else if (take) begin
      acc  <= merged;
      lane <= (lane == LW'(RATIO - 1)) ? '0 : lane + LW'(1);
    end
  end
endmodule

// File: rtl/bpf_ram.sv
module bpf_ram #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bpf_track.sv
module bpf_track #(
  parameter int RATIO    = 4,
  parameter int DEPTH_IN = 1024,
  parameter int THRESH   = 500,
  parameter int AW       = 8,
  parameter int LW       = 2,
  localparam int CW      = $clog2(DEPTH_IN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          accept,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] lane,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_addr_nxt,
  output logic          full,
  output logic          empty,
  output logic          prog_full,
  output logic          overflow,
  output logic          underflow
);
  logic [AW:0]   words, words_nxt;
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] lane_nxt;
  logic [CW-1:0] ncnt_nxt;

  always_comb begin
    words_nxt = words + (AW+1)'(push) - (AW+1)'(pop);
    if (push)        lane_nxt = '0;
    else if (accept) lane_nxt = lane + LW'(1);
    else             lane_nxt = lane;
    ncnt_nxt = CW'(words_nxt) * CW'(RATIO) + CW'(lane_nxt);
  end

  assign rd_addr_nxt = rd_ptr + AW'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      words     <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      prog_full <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      words     <= words_nxt;
      wr_ptr    <= wr_ptr + AW'(push);
      rd_ptr    <= rd_addr_nxt;
      full      <= (ncnt_nxt == CW'(DEPTH_IN));
      empty     <= (words_nxt == '0);
      prog_full <= (ncnt_nxt >= CW'(THRESH));
      overflow  <= wr_en && full;
      underflow <= rd_en && empty;
    end
  end
endmodule

// File: rtl/byte_pack_fifo.sv
module byte_pack_fifo
  import bpf_pkg::*;
#(
  parameter int          IN_W         = 8,
  parameter int          OUT_W        = 32,
  parameter int          DEPTH_IN     = 1024,
  parameter int          PFULL_THRESH = 500,
  parameter lane_order_e ORDER        = FIRST_HIGH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IN_W-1:0]  din,
  input  logic             rd_en,
  output logic [OUT_W-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic             prog_full,
  output logic             overflow,
  output logic             underflow
);
  localparam int RATIO     = OUT_W / IN_W;
  localparam int DEPTH_OUT = DEPTH_IN / RATIO;
  localparam int AW        = $clog2(DEPTH_OUT);
  localparam int LW        = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic             accept, pop, push;
  logic [LW-1:0]    lane;
  logic [OUT_W-1:0] word, rdata, byp_data;
  logic [AW-1:0]    wr_ptr, rd_addr_nxt;
  logic             collide, byp_on, zero_hold;

  assign accept = wr_en && !full;
  assign pop    = rd_en && !empty;

  bpf_packer #(.IN_W(IN_W), .RATIO(RATIO), .ORDER(ORDER)) u_pack (
    .clk(clk), .rst(rst), .take(accept), .byte_in(din),
    .lane(lane), .word_done(push), .word(word)
  );

  bpf_track #(
    .RATIO(RATIO), .DEPTH_IN(DEPTH_IN), .THRESH(PFULL_THRESH),
    .AW(AW), .LW(LW)
  ) u_track (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .accept(accept), .push(push), .pop(pop), .lane(lane),
    .wr_ptr(wr_ptr), .rd_addr_nxt(rd_addr_nxt),
    .full(full), .empty(empty), .prog_full(prog_full),
    .overflow(overflow), .underflow(underflow)
  );

  bpf_ram #(.W(OUT_W), .AW(AW)) u_ram (
    .clk(clk), .we(push), .waddr(wr_ptr), .wdata(word),
    .raddr(rd_addr_nxt), .rdata(rdata)
  );

  // The RAM returns old data when the slot being written is also the next
  // head; a one-word bypass register covers that cycle.
  assign collide = push && (wr_ptr == rd_addr_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_on    <= 1'b0;
      byp_data  <= '0;
      zero_hold <= 1'b1;
    end else begin
      byp_on <= collide;
      if (collide) byp_data <= word;
      if (push)    zero_hold <= 1'b0;
    end
  end

  assign dout = zero_hold ? '0 : (byp_on ? byp_data : rdata);
endmodule

// File: rtl/byte_pack_fifo_chk.sv
module byte_pack_fifo_chk #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [OUT_W-1:0] dout,
  input logic             full,
  input logic             empty,
  input logic             prog_full,
  input logic             overflow,
  input logic             underflow
);
  AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_en) |=> empty); // R1
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!empty && !rd_en) |=> $stable(dout)); // R4
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    full |-> !empty); // R5
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(wr_en && full)); // R6
  AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    underflow |-> $past(rd_en && empty)); // R7
  AST_FULL_IMPLIES_PFULL: assert property (@(posedge clk) disable iff (rst)
    full |-> prog_full); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (empty && !full && !prog_full && !overflow && !underflow && dout == '0)); // R9
endmodule

bind byte_pack_fifo byte_pack_fifo_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .dout(dout),
  .full(full), .empty(empty), .prog_full(prog_full),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/sim_byte_pack_fifo.sv
`timescale 1ns/1ps
module sim_byte_pack_fifo;
  localparam int THR0 = 500;
  localparam int THR1 = 498;

  logic clk = 1'b0;
  logic rst, wr_en, rd_en;
  logic [7:0] din;
  logic [31:0] dout0, dout1;
  logic full0, empty0, pf0, ovf0, udf0;
  logic full1, empty1, pf1, ovf1, udf1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byte_pack_fifo #(.PFULL_THRESH(THR0), .ORDER(bpf_pkg::FIRST_HIGH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(dout0),
    .full(full0), .empty(empty0), .prog_full(pf0), .overflow(ovf0), .underflow(udf0));
  byte_pack_fifo #(.PFULL_THRESH(THR1), .ORDER(bpf_pkg::FIRST_LOW)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(dout1),
    .full(full1), .empty(empty1), .prog_full(pf1), .overflow(ovf1), .underflow(udf1));

  // byte stream of each group, earliest byte in the top lane, and the
  // word expected with earliest-in-bottom order
  localparam logic [31:0] VEC_HI [8] = '{32'h01020304, 32'hA5A5A5A5, 32'hFF00FF00,
    32'h00000001, 32'h80000000, 32'hDEADBEEF, 32'h12345678, 32'hFFFFFFFF};
  localparam logic [31:0] VEC_LO [8] = '{32'h04030201, 32'hA5A5A5A5, 32'h00FF00FF,
    32'h01000000, 32'h00000080, 32'hEFBEADDE, 32'h78563412, 32'hFFFFFFFF};

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    din = b; wr_en = 1'b1; step(); wr_en = 1'b0;
  endtask

  task automatic pop1();
    rd_en = 1'b1; step(); rd_en = 1'b0;
  endtask

  initial begin
    #1200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; din = '0;
    step(); step(); step();
    rst = 1'b0;
    // R9 reset state
    check("R9 empty", {31'd0, empty0 & empty1}, 32'd1);
    check("R9 flags", {27'd0, full0|full1, pf0|pf1, ovf0|ovf1, udf0|udf1, 1'b0}, 32'd0);
    check("R9 dout0", dout0, 32'd0);
    check("R9 dout1", dout1, 32'd0);

    // R1 partial group stays invisible
    put(8'h11); put(8'h22); put(8'h33);
    check("R1 partial empty", {30'd0, empty0, empty1}, 32'd3);
    put(8'h44);
    // R4 fall-through right after the fourth byte
    check("R4 not empty", {30'd0, empty0, empty1}, 32'd0);
    check("R2 order high", dout0, 32'h11223344);
    check("R3 order low", dout1, 32'h44332211);
    pop1();
    check("R4 pop to empty", {30'd0, empty0, empty1}, 32'd3);

    // table walk: R2, R3, R4
    for (int v = 0; v < 8; v++)
      for (int b = 0; b < 4; b++) put(8'(VEC_HI[v] >> (24 - 8*b)));
    for (int v = 0; v < 8; v++) begin
      check("R2 table", dout0, VEC_HI[v]);
      check("R3 table", dout1, VEC_LO[v]);
      pop1();
    end
    check("R4 drained", {30'd0, empty0, empty1}, 32'd3);

    // R7 underflow
    rd_en = 1'b1; step(); rd_en = 1'b0;
    check("R7 underflow pulse", {30'd0, udf0, udf1}, 32'd3);
    step();
    check("R7 underflow clears", {30'd0, udf0, udf1}, 32'd0);
    check("R7 still empty", {30'd0, empty0, empty1}, 32'd3);

    // R10 word completes while the only stored word is popped
    put(8'hA0); put(8'hA1); put(8'hA2); put(8'hA3);
    put(8'hB0); put(8'hB1); put(8'hB2);
    din = 8'hB3; wr_en = 1'b1; rd_en = 1'b1; step(); wr_en = 1'b0; rd_en = 1'b0;
    check("R10 not empty", {30'd0, empty0, empty1}, 32'd0);
    check("R10 new word high", dout0, 32'hB0B1B2B3);
    check("R10 new word low", dout1, 32'hB3B2B1B0);
    pop1();
    check("R10 empty after", {30'd0, empty0, empty1}, 32'd3);

    // R5 / R8 fill to capacity
    for (int i = 0; i < 1024; i++) begin
      put(8'(i));
      check("R8 pfull high order", {31'd0, pf0}, {31'd0, (i + 1) >= THR0});
      check("R8 pfull low order", {31'd0, pf1}, {31'd0, (i + 1) >= THR1});
      check("R5 full", {30'd0, full0, full1}, ((i + 1) == 1024) ? 32'd3 : 32'd0);
    end
    // R6 rejected write
    din = 8'hEE; wr_en = 1'b1; step(); wr_en = 1'b0;
    check("R6 overflow pulse", {30'd0, ovf0, ovf1}, 32'd3);
    check("R5 still full", {30'd0, full0, full1}, 32'd3);
    step();
    check("R6 overflow clears", {30'd0, ovf0, ovf1}, 32'd0);
    // drain: R5 contents intact, R8 falling edge
    for (int k = 0; k < 256; k++) begin
      check("R5 content high", dout0, {8'(4*k), 8'(4*k+1), 8'(4*k+2), 8'(4*k+3)});
      check("R5 content low", dout1, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
      pop1();
      check("R8 pfull drain", {30'd0, pf0, pf1},
            {30'd0, (1024 - 4*(k+1)) >= THR0, (1024 - 4*(k+1)) >= THR1});
      check("R4 empty drain", {30'd0, empty0, empty1}, (k == 255) ? 32'd3 : 32'd0);
    end
    // R5 rejected write left byte position unchanged
    put(8'h05); put(8'h06); put(8'h07); put(8'h08);
    check("R5 alignment high", dout0, 32'h05060708);
    check("R5 alignment low", dout1, 32'h08070605);
    pop1();

    // R9 reset during operation discards words and the partial group
    put(8'h21); put(8'h22); put(8'h23); put(8'h24); put(8'h25); put(8'h26);
    rst = 1'b1; step(); rst = 1'b0;
    check("R9 mid empty", {30'd0, empty0, empty1}, 32'd3);
    check("R9 mid dout", dout0 | dout1, 32'd0);
    put(8'h31); put(8'h32);
    check("R9 partial cleared", {30'd0, empty0, empty1}, 32'd3);
    put(8'h33); put(8'h34);
    check("R9 new group high", dout0, 32'h31323334);
    check("R9 new group low", dout1, 32'h34333231);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule